// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits between a set of interrupt source groups and a small processor core. It decides which group to signal to the core, and when. Each group has a request flag held inside the block and an enable level supplied from outside. A 4-bit priority register holds a master enable and a 3-bit selection that names one group as high priority. The block keeps two service-level flags, low and high, so it knows whether a pending request may interrupt the handler that is currently running.

The request output `irq_o` works as a valid signal and `ack_i` as the matching ready. An acknowledge is honoured only in a cycle where `irq_o` is 1. An acknowledge takes the group named on `vec_o`, clears its request flag and marks the matching service level active. While `irq_o` is high and no acknowledge arrives, `vec_o` may change if a better-qualified request appears. The core must sample both signals in the same cycle. A return pulse closes the innermost active level. Requests that lost arbitration stay pending and are offered again once the levels allow them.

When the selection is zero, every group is low priority. The first handler accepted then runs to the end without interruption, and requests that arrive together are ordered by group number, with group 1 first. When a group is selected, that group may interrupt a running low-priority handler. Nothing interrupts a running high-priority handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the priority register is all zeros, the request flags are clear, `irq_o` is 0, `vec_o` is 0 and `nest_o` is 2'b00.
- R2: Register bit 3 is the master enable, and while it is 0 `irq_o` stays 0. An `ei_i` pulse sets it and a `di_i` pulse clears it. `di_i` wins over `ei_i`, and both win over a register write, which otherwise loads bit 3 from `cfg_wdata_i[3]`.
- R3: A group is pending only when its request flag and its `en_i` bit are both 1. Bit i-1 of `req_set_i` and of `en_i` belongs to group i, and a `req_set_i` bit sets that group's request flag.
- R4: With no service level active, the selected group is signalled if it is pending. Otherwise the pending group with the smallest number is signalled. `vec_o` carries the group number 1 to 7, and it is 0 whenever `irq_o` is 0.
- R5: While only the low level is active, only the selected group (selection 1 to 7) can raise `irq_o`. Other pending groups wait.
- R6: While the high level is active, `irq_o` is 0.
- R7: With selection 000, a running handler is never interrupted. Losing requests stay pending and are signalled after the return pulse.
- R8: An acknowledge with `irq_o` at 1 clears the request flag of the group on `vec_o`. It sets the high level if that group equals a nonzero selection, and the low level otherwise. An acknowledge while `irq_o` is 0 has no effect.
- R9: A return pulse clears the high level if it is set, and clears the low level otherwise. `nest_o` is {high, low}.
- R10: A register write leaves bits 2:0 unchanged if bit 3 is 1 at the time of the write.
- R11: `irq_o` and `vec_o` are registered. They show the state that results from the inputs sampled at a clock edge right after that same edge, and never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 7 | Per-group request set pulses |
| en_i | input | 7 | Per-group enable levels |
| cfg_we_i | input | 1 | Priority register write strobe |
| cfg_wdata_i | input | 4 | Write data: bit 3 master enable, bits 2:0 high-priority selection |
| ei_i | input | 1 | Pulse that sets the master enable |
| di_i | input | 1 | Pulse that clears the master enable |
| ack_i | input | 1 | Core accepts the signalled group |
| ret_i | input | 1 | Core returns from the innermost handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 3 | Number of the group being signalled |
| nest_o | output | 2 | Active service levels {high, low} |

## Verification
The bench builds the block with its defaults: seven groups and a 3-bit selection field. With these values every selection code names a real group, and group 1, the top of the fixed order, can be set against a selected group further down the order. This exposes any case where the selection is ignored in favour of group number. The defaults also allow a two-deep nest (low, then high) with a third request left waiting, so the order in which return pulses unwind the levels can be observed at `nest_o` and `vec_o`.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef struct packed {
    logic high;
    logic low;
  } nest_t;
endpackage

// File: rtl/irqp_cfg.sv
module irqp_cfg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W:0]   wdata,
  input  logic             ei,
  input  logic             di,
  output logic             ime_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             ime_nx,
  output logic [SEL_W-1:0] sel_nx
);
  always_comb begin
    if (di)      ime_nx = 1'b0;
    else if (ei) ime_nx = 1'b1;
    else if (we) ime_nx = wdata[SEL_W];
    else         ime_nx = ime_q;
    sel_nx = (we && !ime_q) ? wdata[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
      sel_q <= '0;
    end else begin
      ime_q <= ime_nx;
      sel_q <= sel_nx;
    end
  end

  assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ime_q |=> $stable(sel_q));
  assert_di_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> !ime_q);
endmodule

// File: rtl/irqp_nest.sv
module irqp_nest
  import irqp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ack_fire,
  input  logic  ack_high,
  input  logic  ret,
  output nest_t lvl_q,
  output nest_t lvl_nx
);
  always_comb begin
    lvl_nx = lvl_q;
    if (ret) begin
      if (lvl_q.high) lvl_nx.high = 1'b0;
      else            lvl_nx.low  = 1'b0;
    end
    if (ack_fire) begin
      if (ack_high) lvl_nx.high = 1'b1;
      else          lvl_nx.low  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_nx;
  end

  assert_ret_high_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && lvl_q.high && !ack_fire) |=> (!lvl_q.high && lvl_q.low == $past(lvl_q.low)));
endmodule

// File: rtl/irqp_arb.sv
module irqp_arb #(
  parameter int NUM_GRP = 7,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_GRP-1:0] pend,
  input  logic [SEL_W-1:0]   sel,
  input  logic               ime,
  input  logic               low_act,
  input  logic               high_act,
  output logic               hit,
  output logic [SEL_W-1:0]   code
);
  logic [NUM_GRP-1:0] sel_mask;
  logic [NUM_GRP-1:0] elig;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    assign sel_mask[g] = (sel == SEL_W'(g + 1));
  end

  always_comb begin
    if (high_act)     elig = '0;
    else if (low_act) elig = pend & sel_mask;
    else              elig = pend;
    hit  = ime && (elig != '0);
    code = '0;
    if (hit) begin
      if ((elig & sel_mask) != '0) begin
        code = sel;
      end else begin
        for (int g = NUM_GRP - 1; g >= 0; g--) begin
          if (elig[g]) code = SEL_W'(g + 1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqp_pkg::*;
#(
  parameter int NUM_GRP = 7,
  localparam int SEL_W  = $clog2(NUM_GRP + 1),
  localparam int PRI_W  = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] req_set_i,
  input  logic [NUM_GRP-1:0] en_i,
  input  logic               cfg_we_i,
  input  logic [PRI_W-1:0]   cfg_wdata_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               ack_i,
  input  logic               ret_i,
  output logic               irq_o,
  output logic [SEL_W-1:0]   vec_o,
  output logic [1:0]         nest_o
);
  logic               ime_q, ime_nx;
  logic [SEL_W-1:0]   sel_q, sel_nx;
  nest_t              lvl_q, lvl_nx;
  logic [NUM_GRP-1:0] req_q, req_nx, clr_mask;
  logic               irq_q, hit;
  logic [SEL_W-1:0]   vec_q, code;
  logic               ack_fire, ack_high;

  irqp_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .wdata(cfg_wdata_i),
    .ei(ei_i), .di(di_i), .ime_q(ime_q), .sel_q(sel_q),
    .ime_nx(ime_nx), .sel_nx(sel_nx)
  );

  assign ack_fire = ack_i && irq_q;
  assign ack_high = (sel_q != '0) && (vec_q == sel_q);

  irqp_nest u_nest (
    .clk(clk), .rst_n(rst_n), .ack_fire(ack_fire), .ack_high(ack_high),
    .ret(ret_i), .lvl_q(lvl_q), .lvl_nx(lvl_nx)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_clr
    assign clr_mask[g] = ack_fire && (vec_q == SEL_W'(g + 1));
  end

  assign req_nx = (req_q & ~clr_mask) | req_set_i;

  irqp_arb #(.NUM_GRP(NUM_GRP), .SEL_W(SEL_W)) u_arb (
    .pend(req_nx & en_i), .sel(sel_nx), .ime(ime_nx),
    .low_act(lvl_nx.low), .high_act(lvl_nx.high), .hit(hit), .code(code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= req_nx;
      irq_q <= hit;
      vec_q <= code;
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign nest_o = {lvl_q.high, lvl_q.low};

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ime_q);
  assert_vec_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0));
  assert_low_only_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.low && irq_o) |-> (sel_q != '0 && vec_o == sel_q));
  assert_high_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q.high |-> !irq_o);
  assert_first_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q.low && sel_q == '0) |-> !irq_o);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (((req_q & $past(clr_mask)) == '0) || (($past(req_set_i) & $past(clr_mask)) != '0)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] req_set = '0;
  logic [6:0] en = 7'h7F;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic       ei = 1'b0, di = 1'b0, ack = 1'b0, ret = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic [1:0] nest;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .en_i(en),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .ei_i(ei), .di_i(di),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_o(vec), .nest_o(nest)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic p_set(input logic [6:0] m); req_set = m; tick(); req_set = '0; endtask
  task automatic p_ack(); ack = 1'b1; tick(); ack = 1'b0; endtask
  task automatic p_ret(); ret = 1'b1; tick(); ret = 1'b0; endtask
  task automatic p_ei(); ei = 1'b1; tick(); ei = 1'b0; endtask
  task automatic p_di(); di = 1'b1; tick(); di = 1'b0; endtask
  task automatic p_wr(input logic [3:0] d); we = 1'b1; wdata = d; tick(); we = 1'b0; endtask

  task automatic t_reset();
    chk("R1 irq", irq, 0);
    chk("R1 vec", vec, 0);
    chk("R1 nest", nest, 0);
  endtask

  task automatic t_mask();
    p_set(7'b0000100);
    chk("R2 masked irq", irq, 0);
    p_ei();
    chk("R2 ei irq", irq, 1);
    chk("R2 ei vec", vec, 3);
    en = 7'h7B; tick();
    chk("R3 disabled irq", irq, 0);
    en = 7'h7F; tick();
    chk("R3 enabled vec", vec, 3);
    ei = 1'b1; di = 1'b1; tick(); ei = 1'b0; di = 1'b0;
    chk("R2 di wins", irq, 0);
    p_wr(4'b1000);
    chk("R2 write sets", irq, 1);
    p_wr(4'b0000);
    chk("R2 write clears", irq, 0);
    p_ei();
    p_ack();
    chk("R8 ack low", nest, 1);
    chk("R8 ack irq", irq, 0);
    p_ret();
    chk("R9 ret low", nest, 0);
    chk("R8 req cleared", irq, 0);
    p_ack();
    chk("R8 ack idle ignored", nest, 0);
  endtask

  task automatic t_order();
    p_set(7'b1010010);
    chk("R4 fixed order", vec, 2);
    p_ack();
    chk("R7 no preempt", irq, 0);
    p_ret();
    chk("R7 next vec", vec, 5);
    p_ack(); p_ret();
    chk("R7 last vec", vec, 7);
    p_ack(); p_ret();
    chk("R7 drained", irq, 0);
  endtask

  task automatic t_high();
    p_di();
    p_wr(4'b1110);
    p_set(7'b0100001);
    chk("R4 selected first", vec, 6);
    p_ack();
    chk("R8 ack high", nest, 2);
    chk("R6 high blocks", irq, 0);
    p_ret();
    chk("R9 ret high", nest, 0);
    chk("R4 group1 next", vec, 1);
    p_ack();
    chk("R8 ack low2", nest, 1);
    p_set(7'b0000100);
    chk("R5 low blocks other", irq, 0);
    p_set(7'b0100000);
    chk("R5 sel preempts", vec, 6);
    p_ack();
    chk("R8 nested", nest, 3);
    chk("R6 nested quiet", irq, 0);
    p_ret();
    chk("R9 high first", nest, 1);
    chk("R5 still blocked", irq, 0);
    p_ret();
    chk("R9 low cleared", nest, 0);
    chk("R7 waiting runs", vec, 3);
    p_ack(); p_ret();
  endtask

  task automatic t_lock();
    p_wr(4'b1010);
    p_set(7'b0000001);
    chk("R4 vec1", vec, 1);
    p_ack();
    p_set(7'b0000010);
    chk("R10 sel unchanged", irq, 0);
    p_set(7'b0100000);
    chk("R10 sel still six", vec, 6);
    p_ack(); p_ret(); p_ret();
    chk("R10 group2 pending", vec, 2);
    p_ack(); p_ret();
    chk("R10 drained", irq, 0);
  endtask

  task automatic t_timing();
    req_set = 7'b0001000;
    #1;
    chk("R11 not early", irq, 0);
    tick();
    req_set = '0;
    chk("R11 after edge", vec, 4);
    p_ack(); p_ret();
    chk("R11 drained", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mask();
    t_order();
    t_high();
    t_lock();
    t_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule